// File: doc/BRIEF.md
# Dual-strobe up/down counter

A 4-bit synchronous up/down counter that is stepped by two separate strobes instead of a clock and a direction bit. Both strobes idle high. A count step occurs on the rising (trailing) edge of a strobe, and only while the other strobe stays high. A free-running system clock samples both strobes through a two-stage synchronizer, and an edge detector turns each trailing edge into a single-cycle step.

A synchronous active-low load copies the parallel data input into the count. A synchronous active-high clear forces zero. Clear wins over load, and load wins over a step. Two active-low wrap flags, carry and borrow, rest high. Each goes low while the count sits at its terminal value and the matching strobe is low. This gives a pulse whose width follows the strobe's low phase, so the flag can drive the strobe input of a next stage.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes 0 and both strobe synchronizers load the idle (high) level, so `carry_n` and `borrow_n` are high after reset.
- R2: A rising edge on `inc_stb_n` while `dec_stb_n` is high adds one to the count. The new value appears after the third rising clock edge that follows the edge being applied: two synchronizer stages, then the count register.
- R3: A rising edge on `dec_stb_n` while `inc_stb_n` is high subtracts one from the count, with the same latency as R2.
- R4: An up step at count 15 gives 0. `carry_n` is low exactly while the count is 15 and the synchronized increment strobe (the pin value two clock edges earlier) is low, and is high otherwise.
- R5: A down step at count 0 gives 15. `borrow_n` is low exactly while the count is 0 and the synchronized decrement strobe is low, and is high otherwise. The two flags are never low together.
- R6: With `load_n` low at a clock edge and `clear` low, the count takes the value of `load_data`.
- R7: With `clear` high at a clock edge, the count becomes 0, whatever `load_n` and the strobes do.
- R8: A step that falls on a cycle with `load_n` low is dropped, and the count takes `load_data`.
- R9: Once both synchronized strobes have been low in the same cycle, the trailing edges that end that overlap produce no step. Counting resumes only after both are seen high together.
- R10: With `clear` low, `load_n` high and no step, the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_stb_n | input | 1 | Count-up strobe, idle high, steps on its rising edge |
| dec_stb_n | input | 1 | Count-down strobe, idle high, steps on its rising edge |
| load_n | input | 1 | Synchronous active-low parallel load |
| clear | input | 1 | Synchronous active-high clear |
| load_data | input | WIDTH (4) | Parallel load value |
| count_q | output | WIDTH (4) | Current count |
| carry_n | output | 1 | Active-low overflow flag |
| borrow_n | output | 1 | Active-low underflow flag |

## Verification
On every cycle, the assertions check the following:
- the priority order of clear, load and step;
- that each step changes the count by exactly one, including both wraps;
- that a count with no command holds;
- that the two steps never fire together;
- that no step follows a cycle with both strobes low;
- that the flags are never low together.

Some behaviour only the bench's scenarios can show:
- the three-edge latency from a strobe pin to the count;
- that a flag pulse lasts as long as the strobe's low phase;
- that both strobes must return high before counting resumes after an overlap.

The bench shows these by running a behavioural reference model cycle by cycle alongside directed and pseudo-random strobe traffic.

// File: rtl/ds_counter_pkg.sv
package ds_counter_pkg;

    // Operation chosen by the count core in one cycle.
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_DEC,
        OP_LOAD,
        OP_CLEAR
    } cnt_op_e;

    // Control bundle handed to the count core.
    typedef struct packed {
        logic clear;
        logic load;
        logic step_up;
        logic step_dn;
    } cnt_ctrl_t;

    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned CNT_WIDTH_DEF   = 4;

    // Priority: clear, then load, then steps.
    function automatic cnt_op_e pick_op(input cnt_ctrl_t c);
        if (c.clear)        return OP_CLEAR;
        else if (c.load)    return OP_LOAD;
        else if (c.step_up) return OP_INC;
        else if (c.step_dn) return OP_DEC;
        else                return OP_HOLD;
    endfunction

    // Both strobe levels low: the overlap state.
    function automatic logic both_low(input logic a_n, input logic b_n);
        return (~a_n) & (~b_n);
    endfunction

    // Both strobe levels high: the idle state.
    function automatic logic both_high(input logic a_n, input logic b_n);
        return a_n & b_n;
    endfunction

endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
    parameter int unsigned LINES  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);
    logic [LINES-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ds_step_detect.sv
module ds_step_detect
    import ds_counter_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl_up_n,
    input  logic lvl_dn_n,
    output logic step_up,
    output logic step_dn
);
    logic prev_up_q;
    logic prev_dn_q;
    logic lock_q;
    logic lock_d;

    always_comb begin
        if (both_low(lvl_up_n, lvl_dn_n))       lock_d = 1'b1;
        else if (both_high(lvl_up_n, lvl_dn_n)) lock_d = 1'b0;
        else                                    lock_d = lock_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_up_q <= 1'b1;
            prev_dn_q <= 1'b1;
            lock_q    <= 1'b0;
        end else begin
            prev_up_q <= lvl_up_n;
            prev_dn_q <= lvl_dn_n;
            lock_q    <= lock_d;
        end
    end

    // Trailing edge of one strobe while the other idles high, outside an overlap.
    assign step_up = lvl_up_n & ~prev_up_q & lvl_dn_n & ~lock_q;
    assign step_dn = lvl_dn_n & ~prev_dn_q & lvl_up_n & ~lock_q;

    // R9: a cycle with both strobes low is never followed by a step.
    p_overlap_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (!lvl_up_n && !lvl_dn_n) |=> (!step_up && !step_dn));

    // R9: the two steps never fire together.
    p_steps_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({step_up, step_dn}));
endmodule

// File: rtl/ds_count_core.sv
module ds_count_core
    import ds_counter_pkg::*;
#(
    parameter int unsigned WIDTH = CNT_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_ctrl_t        ctrl,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] count_q
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;
    localparam logic [WIDTH-1:0] CNT_ONE = WIDTH'(1);

    cnt_op_e          op;
    logic [WIDTH-1:0] count_d;

    assign op = pick_op(ctrl);

    always_comb begin
        unique case (op)
            OP_CLEAR: count_d = '0;
            OP_LOAD:  count_d = load_data;
            OP_INC:   count_d = count_q + CNT_ONE;
            OP_DEC:   count_d = count_q - CNT_ONE;
            default:  count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl.clear |=> (count_q == '0));

    p_load_value_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && ctrl.load) |=> (count_q == $past(load_data)));

    p_load_over_step_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && ctrl.load && (ctrl.step_up || ctrl.step_dn))
            |=> (count_q == $past(load_data)));

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.load && ctrl.step_up)
            |=> (count_q == WIDTH'($past(count_q) + CNT_ONE)));

    p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.load && ctrl.step_dn && !ctrl.step_up)
            |=> (count_q == WIDTH'($past(count_q) - CNT_ONE)));

    p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.load && ctrl.step_up && count_q == CNT_MAX)
            |=> (count_q == '0));

    p_wrap_dn_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.load && ctrl.step_dn && !ctrl.step_up && count_q == '0)
            |=> (count_q == CNT_MAX));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.load && !ctrl.step_up && !ctrl.step_dn)
            |=> $stable(count_q));
endmodule

// File: rtl/ds_wrap_flags.sv
module ds_wrap_flags #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] count_q,
    input  logic             lvl_up_n,
    input  logic             lvl_dn_n,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic at_top;
    logic at_bottom;

    assign at_top    = (count_q == CNT_MAX);
    assign at_bottom = (count_q == '0);

    // Low while the terminal count is present and the matching strobe is low.
    assign carry_n  = ~(at_top & ~lvl_up_n);
    assign borrow_n = ~(at_bottom & ~lvl_dn_n);
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
    import ds_counter_pkg::*;
#(
    parameter int unsigned WIDTH       = CNT_WIDTH_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_stb_n,
    input  logic             dec_stb_n,
    input  logic             load_n,
    input  logic             clear,
    input  logic [WIDTH-1:0] load_data,
    output logic [WIDTH-1:0] count_q,
    output logic             carry_n,
    output logic             borrow_n
);
    logic [1:0] stb_sync;
    logic       lvl_up_n;
    logic       lvl_dn_n;
    logic       step_up;
    logic       step_dn;
    cnt_ctrl_t  ctrl;

    ds_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({dec_stb_n, inc_stb_n}),
        .sync_out (stb_sync)
    );

    assign lvl_up_n = stb_sync[0];
    assign lvl_dn_n = stb_sync[1];

    ds_step_detect u_step (
        .clk      (clk),
        .rst      (rst),
        .lvl_up_n (lvl_up_n),
        .lvl_dn_n (lvl_dn_n),
        .step_up  (step_up),
        .step_dn  (step_dn)
    );

    always_comb begin
        ctrl.clear   = clear;
        ctrl.load    = ~load_n;
        ctrl.step_up = step_up;
        ctrl.step_dn = step_dn;
    end

    ds_count_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .load_data (load_data),
        .count_q   (count_q)
    );

    ds_wrap_flags #(.WIDTH(WIDTH)) u_flags (
        .count_q  (count_q),
        .lvl_up_n (lvl_up_n),
        .lvl_dn_n (lvl_dn_n),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // R5: overflow and underflow flags are never active together.
    p_flags_apart_r5: assert property (@(posedge clk) disable iff (rst)
        !(!carry_n && !borrow_n));

    // R1: the cycle after reset shows zero count and idle flags.
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (count_q == '0 && carry_n && borrow_n));
endmodule

// File: tb/dual_strobe_counter_bench.sv
module dual_strobe_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       inc_stb_n = 1'b1;
    logic       dec_stb_n = 1'b1;
    logic       load_n = 1'b1;
    logic       clear = 1'b0;
    logic [3:0] load_data = 4'd0;
    logic [3:0] count_q;
    logic       carry_n;
    logic       borrow_n;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    finished = 0;

    // Reference model state: strobe sample history and a count.
    int m_cnt = 0;
    bit iq [0:2] = '{1, 1, 1};
    bit dq [0:2] = '{1, 1, 1};
    bit m_lock = 0;

    always #2 clk = ~clk;

    dual_strobe_counter u_dual_strobe_counter (
        .clk(clk), .rst(rst), .inc_stb_n(inc_stb_n), .dec_stb_n(dec_stb_n),
        .load_n(load_n), .clear(clear), .load_data(load_data),
        .count_q(count_q), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    always @(posedge clk) begin
        bit up, dn, nl;
        if (rst) begin
            m_cnt  = 0;
            iq     = '{1, 1, 1};
            dq     = '{1, 1, 1};
            m_lock = 0;
        end else begin
            up = iq[1] && !iq[2] && dq[1] && !m_lock;
            dn = dq[1] && !dq[2] && iq[1] && !m_lock;
            if (!iq[1] && !dq[1])     nl = 1;
            else if (iq[1] && dq[1])  nl = 0;
            else                      nl = m_lock;
            if (clear)        m_cnt = 0;
            else if (!load_n) m_cnt = load_data;
            else if (up)      m_cnt = (m_cnt + 1) % 16;
            else if (dn)      m_cnt = (m_cnt + 15) % 16;
            iq[2] = iq[1]; iq[1] = iq[0]; iq[0] = inc_stb_n;
            dq[2] = dq[1]; dq[1] = dq[0]; dq[0] = dec_stb_n;
            m_lock = nl;
        end
        started = 1;
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (started && !finished) begin
            check(cur_req, count_q, m_cnt, "count vs model");
            check("R4", carry_n, !(m_cnt == 15 && !iq[1]), "carry_n vs model");
            check("R5", borrow_n, !(m_cnt == 0 && !dq[1]), "borrow_n vs model");
        end
    end

    task automatic pulse_up(input int low);
        @(negedge clk) inc_stb_n = 1'b0;
        repeat (low) @(negedge clk);
        inc_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_dn(input int low);
        @(negedge clk) dec_stb_n = 1'b0;
        repeat (low) @(negedge clk);
        dec_stb_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_load(input int val);
        @(negedge clk) begin load_data = val[3:0]; load_n = 1'b0; end
        @(negedge clk) load_n = 1'b1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", count_q, 0, "reset count");
        check("R1", carry_n, 1, "reset carry_n");
        check("R1", borrow_n, 1, "reset borrow_n");

        // R2: three up steps, latency of three edges after release.
        cur_req = "R2";
        @(negedge clk) inc_stb_n = 1'b0;
        repeat (2) @(negedge clk);
        inc_stb_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2", count_q, 0, "count before third edge");
        @(negedge clk);
        check("R2", count_q, 1, "count after third edge");
        pulse_up(1);
        pulse_up(3);
        check("R2", count_q, 3, "three up steps");

        // R6: load.
        cur_req = "R6";
        do_load(14);
        check("R6", count_q, 14, "loaded value");

        // R4: climb to 15, then a long up pulse wraps to 0 with carry low.
        cur_req = "R4";
        pulse_up(2);
        check("R4", count_q, 15, "at top");
        @(negedge clk) inc_stb_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4", carry_n, 0, "carry low during strobe low at 15");
        repeat (3) @(negedge clk);
        check("R4", carry_n, 0, "carry still low in long strobe");
        inc_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R4", count_q, 0, "wrapped to 0");
        check("R4", carry_n, 1, "carry back high");

        // R5: long down pulse at 0.
        cur_req = "R5";
        @(negedge clk) dec_stb_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R5", borrow_n, 0, "borrow low during strobe low at 0");
        dec_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R5", count_q, 15, "wrapped to 15");
        check("R5", borrow_n, 1, "borrow back high");

        // R3: down steps.
        cur_req = "R3";
        pulse_dn(1);
        pulse_dn(2);
        pulse_dn(5);
        check("R3", count_q, 12, "three down steps");

        // R7: clear wins over load.
        cur_req = "R7";
        @(negedge clk) begin clear = 1'b1; load_n = 1'b0; load_data = 4'd9; end
        @(negedge clk) begin clear = 1'b0; load_n = 1'b1; end
        check("R7", count_q, 0, "clear beats load");

        // R8: load held low through an up step.
        cur_req = "R8";
        @(negedge clk) begin load_n = 1'b0; load_data = 4'd6; end
        pulse_up(2);
        check("R8", count_q, 6, "step dropped under load");
        @(negedge clk) load_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", count_q, 6, "hold with no command");

        // R9: overlap, staggered release, then simultaneous release.
        cur_req = "R9";
        @(negedge clk) begin inc_stb_n = 1'b0; dec_stb_n = 1'b0; end
        repeat (3) @(negedge clk);
        inc_stb_n = 1'b1;
        repeat (3) @(negedge clk);
        dec_stb_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", count_q, 6, "staggered overlap release");
        @(negedge clk) begin inc_stb_n = 1'b0; dec_stb_n = 1'b0; end
        repeat (3) @(negedge clk);
        begin inc_stb_n = 1'b1; dec_stb_n = 1'b1; end
        repeat (4) @(negedge clk);
        check("R9", count_q, 6, "joint overlap release");
        pulse_up(1);
        check("R9", count_q, 7, "counting resumes after overlap");

        // R10 and mixed traffic: pseudo-random strobes, loads, clears.
        cur_req = "R10";
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            lfsr = {16'd0, lfsr[15:0]};
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 16'h0);
            if (lfsr[2:0] == 3'd1) inc_stb_n = ~inc_stb_n;
            if (lfsr[5:3] == 3'd2) dec_stb_n = ~dec_stb_n;
            load_n    = !(lfsr[10:6] == 5'd3);
            clear     = (lfsr[15:11] == 5'd7);
            load_data = lfsr[14:11];
        end
        inc_stb_n = 1'b1; dec_stb_n = 1'b1; load_n = 1'b1; clear = 1'b0;
        repeat (6) @(negedge clk);
        finish_run();
    end
endmodule